// File: doc/BRIEF.md
# Pulse-Pause Frame Transmitter

This block turns a parallel command word into a pulse-pause waveform on one coil-control line. The caller presents a data word, a keystream word of the same width and a bit count, then strobes start. The block XORs the keystream onto the data and shifts the result out least significant bit first. Every bit opens with a short, fixed pause in which the coil is shorted. The coil is then released for an on-phase whose length sets the bit value. A final pause after the last bit marks the end of the frame.

All timing is counted on a tick enable (nominally one tick per 1.5 µs). The clock can run faster than the tick. Busy covers the whole frame. A one-cycle done pulse marks the point where the coil is back in its open state and a new frame may be started.

Top module: `pp_frame_tx`

## Requirements
- R1: After reset and whenever idle, coil is 1 (open), busy is 0 and done is 0.
- R2: Every transmitted bit begins with the coil at 0 for exactly PAUSE_TICKS (30) ticks.
- R3: A bit of value 1 lasts 120 ticks in total, pause included. A bit of value 0 lasts 60 ticks in total. During the remainder of the bit the coil is 1.
- R4: Exactly the requested number of bits is sent, bit 0 of the word first.
- R5: The bit pattern sent is data XOR keystream. A keystream bit of 1 inverts the corresponding data bit.
- R6: After the last bit, the coil is held at 0 for one further 30-tick pause and then returns to 1.
- R7: Busy rises in the clock after an accepted start and stays high until the end pause finishes. Done is high for exactly one clock, in the first clock in which busy is low again.
- R8: A start strobe while busy is ignored, and the frame in flight is sent unchanged.
- R9: A bit count of 0 sends only the end pause, with no bits.
- R10: A bit count above 32 is treated as 32.
- R11: Pause and on-phase lengths advance only on clocks where tick is 1. Start is accepted on any clock while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable, one pulse per 1.5 µs tick |
| start | input | 1 | Start strobe, sampled while idle |
| data | input | DATA_W | Frame payload, bit 0 sent first |
| keystream | input | DATA_W | Whitening word XORed onto data |
| nbits | input | CNT_W | Number of bits to send (0 to 32, larger values clamp) |
| coil | output | 1 | Coil control: 1 open (carrier on), 0 shorted (pause) |
| busy | output | 1 | High while a frame, including its end pause, is in progress |
| done | output | 1 | One-clock pulse when a frame completes |

## Verification
The bench decodes the coil waveform by counting ticks in each low and high run. A design that got the on-phase length wrong, or that counted the pause outside the total bit time, yields totals other than 120 or 60 and is flagged at once. A zero-length frame and an oversized count probe the edges of the bit counter: a design without the clamp sends a wrong number of bits, and one that forgets the empty case hangs or emits a bit. A start strobe injected mid-frame catches designs that reload the shift word. Running the same frames with a sparse tick shows whether the timers count clocks rather than ticks, because the pause lengths would then come out short.

// File: rtl/pp_frame_tx.sv
module pp_frame_tx #(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 6,
  parameter int PAUSE_TICKS = 30,
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] keystream,
  input  logic [CNT_W-1:0]  nbits,
  output logic              coil,
  output logic              busy,
  output logic              done
);
  localparam int TW = $clog2(ONE_TICKS + 1);
  localparam logic [TW-1:0] PAUSE_LAST = TW'(PAUSE_TICKS - 1);
  localparam logic [TW-1:0] ON1_LAST   = TW'(ONE_TICKS - PAUSE_TICKS - 1);
  localparam logic [TW-1:0] ON0_LAST   = TW'(ZERO_TICKS - PAUSE_TICKS - 1);
  localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);

  typedef enum logic [1:0] {S_IDLE, S_PAUSE, S_ON, S_END} st_t;

  st_t              st;
  logic [TW-1:0]    tcnt;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0] left;
  logic [CNT_W-1:0] eff;
  logic [TW-1:0]    on_last;

  assign eff     = (nbits > MAX_BITS) ? MAX_BITS : nbits;
  assign on_last = sh[0] ? ON1_LAST : ON0_LAST;
  assign coil    = (st == S_IDLE) || (st == S_ON);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      sh   <= '0;
      left <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sh   <= data ^ keystream;
          left <= eff;
          tcnt <= '0;
          st   <= (eff == '0) ? S_END : S_PAUSE;
        end
        S_PAUSE: if (tick) begin
          if (tcnt == PAUSE_LAST) begin
            tcnt <= '0;
            st   <= S_ON;
          end else tcnt <= tcnt + 1'b1;
        end
        S_ON: if (tick) begin
          if (tcnt == on_last) begin
            tcnt <= '0;
            sh   <= sh >> 1;
            left <= left - 1'b1;
            st   <= (left == CNT_W'(1)) ? S_END : S_PAUSE;
          end else tcnt <= tcnt + 1'b1;
        end
        S_END: if (tick) begin
          if (tcnt == PAUSE_LAST) begin
            tcnt <= '0;
            st   <= S_IDLE;
            done <= 1'b1;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_COIL_OPEN: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> coil); // R1
  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !tick) |=> ($stable(sh) && $stable(left))); // R8
  AST_TICK_GATES: assert property (@(posedge clk) disable iff (!rst_n) (busy && !tick) |=> ($stable(coil) && $stable(tcnt))); // R11
  AST_PAUSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $rose(coil)) |-> ($past(tcnt) == PAUSE_LAST)); // R2
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) left <= MAX_BITS); // R10
endmodule

// File: tb/test_pp_frame_tx.sv
module test_pp_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [31:0] data = '0;
  logic [31:0] keystream = '0;
  logic [5:0]  nbits = '0;
  logic        coil, busy, done;

  int checks = 0;
  int fails = 0;
  int tper = 1;
  int tc = 0;
  bit finished = 1'b0;

  pp_frame_tx i_pp_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .data(data),
    .keystream(keystream), .nbits(nbits), .coil(coil), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick = (tc == 0);
    tc = (tc + 1 >= tper) ? 0 : tc + 1;
  end

  // {nbits, data, keystream}
  localparam logic [69:0] VEC [8] = '{
    {6'd7,  32'h0000_0055, 32'h0000_0000},
    {6'd6,  32'h0000_0019, 32'h0000_002A},
    {6'd32, 32'hDEAD_BEEF, 32'h1234_5678},
    {6'd1,  32'h0000_0001, 32'h0000_0000},
    {6'd1,  32'h0000_0000, 32'h0000_0001},
    {6'd13, 32'h0000_0FFF, 32'h0000_0AAA},
    {6'd11, 32'hFFFF_FFFF, 32'h0000_0000},
    {6'd32, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] d, input logic [31:0] k, input logic [5:0] n,
                           input bit poke, input string tag);
    int lowrun = 0, highrun = 0, pause = 0, nb = 0, badp = 0, badb = 0, cyc = 0;
    bit prev = 1'b1, have = 1'b0;
    logic [31:0] val = '0;
    int en;
    logic [31:0] exp;
    en  = (n > 6'd32) ? 32 : int'(n);
    exp = (en == 0) ? 32'h0 : (en >= 32) ? (d ^ k) : ((d ^ k) & ((32'h1 << en) - 1));
    @(negedge clk);
    data = d; keystream = k; nbits = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {tag, " R7 busy after start"}, busy, 1);
    forever begin
      if (!busy) break;
      if (coil != prev) begin
        if (coil) begin
          pause = lowrun; lowrun = 0;
          if (pause != 30) badp++;
          have = 1'b1;
        end else if (have) begin
          if (pause + highrun == 120) begin val[nb[4:0]] = 1'b1; nb++; end
          else if (pause + highrun == 60) nb++;
          else badb++;
          highrun = 0;
        end
      end
      if (coil) highrun += int'(tick); else lowrun += int'(tick);
      prev = coil;
      if (poke && cyc == 50) begin
        data = ~d; keystream = 32'h0; nbits = 6'd3; start = 1'b1;
      end else start = 1'b0;
      cyc++;
      if (cyc > 20000) begin
        check(1'b0, {tag, " R7 frame timeout"}, cyc, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(badp == 0, {tag, " R2 bit pause length"}, badp, 0);
    check(badb == 0, {tag, " R3 bit total length"}, badb, 0);
    check(nb == en, {tag, " R4 bit count"}, nb, en);
    check(val == exp, {tag, " R5 value sent"}, val, exp);
    check(lowrun == 30 && coil, {tag, " R6 end pause"}, lowrun, 30);
    check(done == 1'b1, {tag, " R7 done at end"}, done, 1);
    @(negedge clk);
    check(done == 1'b0 && !busy && coil, {tag, " R7 done single"}, done, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(coil == 1'b1 && busy == 1'b0 && done == 1'b0, "R1 reset state", {coil, busy, done}, 3'b100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++)
      run_frame(VEC[i][63:32], VEC[i][31:0], VEC[i][69:64], 1'b0, $sformatf("vec%0d", i));
    repeat (5) @(negedge clk);
    check(coil == 1'b1 && !busy, "R1 idle between frames", coil, 1);
    run_frame(32'h0000_0123, 32'h0000_0000, 6'd10, 1'b1, "R8 start while busy");
    run_frame(32'hFFFF_FFFF, 32'h0, 6'd0, 1'b0, "R9 zero bits");
    run_frame(32'hA5A5_0F0F, 32'h0F0F_0000, 6'd40, 1'b0, "R10 clamp");
    tper = 3;
    run_frame(32'h0000_002D, 32'h0000_0011, 6'd6, 1'b0, "R11 sparse tick");
    @(negedge clk);
    tick = 1'b0; tper = 1000; tc = 1;
    @(negedge clk);
    data = 32'h1; keystream = 32'h0; nbits = 6'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(busy && !coil, "R11 no tick holds pause", {busy, coil}, 2'b10);
    tper = 1;
    while (busy) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule